// File: doc/BRIEF.md
# PCI Slot Hot-Plug Event Registers

This block records insertion and removal events for up to 32 PCI slots and presents them to firmware through a small window of 32-bit I/O registers. A platform-side hot-plug controller reports each event as a one-cycle strobe with a slot number and an event kind. Every insertion or removal raises a general-purpose event status bit, which is the firmware interrupt source. Firmware then reads which slot came up or went down. To request removal of a device, firmware writes the eject register. The block turns the lowest set bit of that write into a one-hot eject request pulse, but only for a slot that is not strapped as fixed.

Only the most recent event is kept. Each insertion or removal wipes both event masks before setting its own slot bit. Devices already present at power-on are reported as cold-plug enables, and these leave all state untouched.

Top module: `slot_hotplug_regs`

## Requirements
- R1: After reset, the up mask, the down mask, the event status bit and the eject request vector are all zero.
- R2: The up mask reads at BASE+0x0, the down mask at BASE+0x4 and the removability mask at BASE+0xC. The event status bit reads as bit 1 of the word at GPE_ADDR. Any other address reads as zero.
- R3: A hot-enable event (kind 1) clears the down mask and leaves the up mask holding only the bit of the event's slot.
- R4: A disable event (kind 2) clears the up mask and leaves the down mask holding only the bit of the event's slot.
- R5: Hot-enable and disable events set the event status bit. Writing a word with bit 1 set to GPE_ADDR clears it. When a clear and an event fall in the same cycle, the bit ends up set.
- R6: A cold-enable event (kind 0) and the reserved kind 3 change no mask and do not touch the event status bit.
- R7: A write to BASE+0x8 selects the slot of the lowest set bit of the written word. If that slot is removable, eject_req carries exactly that one bit in the cycle after the write, and returns to zero one cycle later.
- R8: Writing zero to the eject register, or writing a word whose lowest set bit names a slot that is not removable, produces no eject request.
- R9: The removability mask is the complement of the strap vector as sampled during reset. Writes to it have no effect.
- R10: The eject register reads as zero. Writes to the up and down mask addresses have no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| evt_valid | input | 1 | One-cycle event strobe |
| evt_kind | input | 2 | 0 cold-enable, 1 hot-enable, 2 disable, 3 reserved |
| evt_slot | input | 5 | Slot number of the event |
| no_hp_strap | input | 32 | Per-slot "fixed, not removable" strap, sampled in reset |
| io_wr | input | 1 | I/O write strobe |
| io_addr | input | 16 | I/O address for reads and writes |
| io_wdata | input | 32 | I/O write data |
| io_rdata | output | 32 | I/O read data, combinational from io_addr |
| gpe_hp_sts | output | 1 | Hot-plug general-purpose event status |
| eject_req | output | 32 | One-hot eject request pulse |

## Verification
Several properties are checked on every cycle. The two event masks together never hold more than one set bit. An eject pulse is never more than one-hot and never names a non-removable slot. A cycle without an eject write is always followed by an empty eject vector. Every hot-enable or disable event leaves the status bit set, and a cold-enable event leaves both masks stable. Some behaviours can only be shown by the bench scenarios: which exact bit each event sets, the lowest-bit selection in the eject register, the contents of the register window seen at each address, and the fact that writes to read-only locations change nothing.

// File: rtl/hp_pkg.sv
package hp_pkg;

    localparam int SLOTS  = 32;
    localparam int SLOT_W = $clog2(SLOTS);

    typedef logic [SLOTS-1:0]  slot_vec_t;
    typedef logic [SLOT_W-1:0] slot_idx_t;

    typedef enum logic [1:0] {
        EVT_COLD_EN = 2'd0,
        EVT_HOT_EN  = 2'd1,
        EVT_UNPLUG  = 2'd2,
        EVT_RSVD    = 2'd3
    } evt_kind_e;

    typedef struct packed {
        logic      valid;
        evt_kind_e kind;
        slot_idx_t slot;
    } hp_evt_t;

    // register offsets inside the hot-plug window
    localparam logic [3:0] OFS_UP   = 4'h0;
    localparam logic [3:0] OFS_DOWN = 4'h4;
    localparam logic [3:0] OFS_EJ   = 4'h8;
    localparam logic [3:0] OFS_RMV  = 4'hC;

    // status bit position inside the event status byte
    localparam int GPE_HP_BIT = 1;

    function automatic slot_vec_t lowest_set(input slot_vec_t v);
        return v & (~v + slot_vec_t'(1));
    endfunction

    function automatic slot_vec_t slot_bit(input slot_idx_t s);
        return slot_vec_t'(1) << s;
    endfunction

endpackage

// File: rtl/hp_event_masks.sv
module hp_event_masks
    import hp_pkg::*;
(
    input  logic      clk,
    input  logic      rst,
    input  hp_evt_t   evt,
    input  logic      sts_clr,
    output slot_vec_t up_mask,
    output slot_vec_t down_mask,
    output logic      gpe_sts
);

    always_ff @(posedge clk) begin
        if (rst) begin
            up_mask   <= '0;
            down_mask <= '0;
            gpe_sts   <= 1'b0;
        end else begin
            if (sts_clr) gpe_sts <= 1'b0;
            if (evt.valid) begin
                unique case (evt.kind)
                    EVT_HOT_EN: begin
                        up_mask   <= slot_bit(evt.slot);
                        down_mask <= '0;
                        gpe_sts   <= 1'b1;
                    end
                    EVT_UNPLUG: begin
                        up_mask   <= '0;
                        down_mask <= slot_bit(evt.slot);
                        gpe_sts   <= 1'b1;
                    end
                    default: ;
                endcase
            end
        end
    end

    assert_single_event_R3: assert property (@(posedge clk) disable iff (rst)
        $countones({up_mask, down_mask}) <= 1);

    assert_gpe_raised_R5: assert property (@(posedge clk) disable iff (rst)
        (evt.valid && (evt.kind == EVT_HOT_EN || evt.kind == EVT_UNPLUG))
        |=> gpe_sts);

    assert_cold_no_change_R6: assert property (@(posedge clk) disable iff (rst)
        (evt.valid && evt.kind == EVT_COLD_EN)
        |=> ($stable(up_mask) && $stable(down_mask)));

endmodule

// File: rtl/hp_eject_unit.sv
module hp_eject_unit
    import hp_pkg::*;
(
    input  logic      clk,
    input  logic      rst,
    input  slot_vec_t strap_fixed,
    input  logic      ej_wr,
    input  slot_vec_t ej_data,
    output slot_vec_t rmv_mask,
    output slot_vec_t eject_req
);

    slot_vec_t pick;

    always_comb pick = lowest_set(ej_data);

    always_ff @(posedge clk) begin
        if (rst) begin
            rmv_mask  <= ~strap_fixed;
            eject_req <= '0;
        end else begin
            eject_req <= ej_wr ? (pick & rmv_mask) : '0;
        end
    end

    assert_eject_onehot_R7: assert property (@(posedge clk) disable iff (rst)
        $onehot0(eject_req));

    assert_eject_removable_R8: assert property (@(posedge clk) disable iff (rst)
        (eject_req & ~rmv_mask) == '0);

    assert_eject_needs_write_R7: assert property (@(posedge clk) disable iff (rst)
        !ej_wr |=> (eject_req == '0));

endmodule

// File: rtl/slot_hotplug_regs.sv
module slot_hotplug_regs
    import hp_pkg::*;
#(
    parameter int              ADDR_W    = 16,
    parameter logic [ADDR_W-1:0] BASE_ADDR = 16'hAE00,
    parameter logic [ADDR_W-1:0] GPE_ADDR  = 16'hAFE0
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              evt_valid,
    input  logic [1:0]        evt_kind,
    input  logic [4:0]        evt_slot,
    input  logic [31:0]       no_hp_strap,
    input  logic              io_wr,
    input  logic [ADDR_W-1:0] io_addr,
    input  logic [31:0]       io_wdata,
    output logic [31:0]       io_rdata,
    output logic              gpe_hp_sts,
    output logic [31:0]       eject_req
);

    localparam logic [ADDR_W-1:0] A_UP   = BASE_ADDR + ADDR_W'(OFS_UP);
    localparam logic [ADDR_W-1:0] A_DOWN = BASE_ADDR + ADDR_W'(OFS_DOWN);
    localparam logic [ADDR_W-1:0] A_EJ   = BASE_ADDR + ADDR_W'(OFS_EJ);
    localparam logic [ADDR_W-1:0] A_RMV  = BASE_ADDR + ADDR_W'(OFS_RMV);

    hp_evt_t   evt;
    logic      sts_clr;
    logic      ej_wr;
    slot_vec_t up_mask, down_mask, rmv_mask;

    always_comb begin
        evt.valid = evt_valid;
        evt.kind  = evt_kind_e'(evt_kind);
        evt.slot  = evt_slot;
        sts_clr   = io_wr && (io_addr == GPE_ADDR) && io_wdata[GPE_HP_BIT];
        ej_wr     = io_wr && (io_addr == A_EJ);
    end

    hp_event_masks u_masks (
        .clk       (clk),
        .rst       (rst),
        .evt       (evt),
        .sts_clr   (sts_clr),
        .up_mask   (up_mask),
        .down_mask (down_mask),
        .gpe_sts   (gpe_hp_sts)
    );

    hp_eject_unit u_eject (
        .clk         (clk),
        .rst         (rst),
        .strap_fixed (no_hp_strap),
        .ej_wr       (ej_wr),
        .ej_data     (io_wdata),
        .rmv_mask    (rmv_mask),
        .eject_req   (eject_req)
    );

    always_comb begin
        io_rdata = '0;
        if (io_addr == A_UP)        io_rdata = up_mask;
        else if (io_addr == A_DOWN) io_rdata = down_mask;
        else if (io_addr == A_RMV)  io_rdata = rmv_mask;
        else if (io_addr == GPE_ADDR) io_rdata[GPE_HP_BIT] = gpe_hp_sts;
    end

    assert_eject_reads_zero_R10: assert property (@(posedge clk) disable iff (rst)
        (io_addr == A_EJ) |-> (io_rdata == '0));

endmodule

// File: tb/test_slot_hotplug_regs.sv
module test_slot_hotplug_regs;

    localparam logic [15:0] BASE = 16'hAE00;
    localparam logic [15:0] GPE  = 16'hAFE0;
    localparam logic [31:0] STRAP = 32'h0000_0005;

    typedef struct packed {
        logic [1:0]  kind;
        logic [4:0]  slot;
        logic [31:0] up;
        logic [31:0] down;
        logic        gpe;
    } vec_t;

    localparam int NV = 7;
    localparam vec_t VECS [NV] = '{
        '{kind: 2'd1, slot: 5'd3,  up: 32'h0000_0008, down: 32'h0,          gpe: 1'b1},
        '{kind: 2'd1, slot: 5'd31, up: 32'h8000_0000, down: 32'h0,          gpe: 1'b1},
        '{kind: 2'd2, slot: 5'd0,  up: 32'h0,          down: 32'h0000_0001, gpe: 1'b1},
        '{kind: 2'd0, slot: 5'd5,  up: 32'h0,          down: 32'h0000_0001, gpe: 1'b0},
        '{kind: 2'd3, slot: 5'd7,  up: 32'h0,          down: 32'h0000_0001, gpe: 1'b0},
        '{kind: 2'd2, slot: 5'd17, up: 32'h0,          down: 32'h0002_0000, gpe: 1'b1},
        '{kind: 2'd1, slot: 5'd0,  up: 32'h0000_0001, down: 32'h0,          gpe: 1'b1}
    };

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        evt_valid = 1'b0;
    logic [1:0]  evt_kind = '0;
    logic [4:0]  evt_slot = '0;
    logic [31:0] no_hp_strap = STRAP;
    logic        io_wr = 1'b0;
    logic [15:0] io_addr = '0;
    logic [31:0] io_wdata = '0;
    logic [31:0] io_rdata;
    logic        gpe_hp_sts;
    logic [31:0] eject_req;

    int checks = 0;
    int failures = 0;
    bit done = 1'b0;

    always #2 clk = ~clk;

    slot_hotplug_regs i_slot_hotplug_regs (
        .clk(clk), .rst(rst), .evt_valid(evt_valid), .evt_kind(evt_kind),
        .evt_slot(evt_slot), .no_hp_strap(no_hp_strap), .io_wr(io_wr),
        .io_addr(io_addr), .io_wdata(io_wdata), .io_rdata(io_rdata),
        .gpe_hp_sts(gpe_hp_sts), .eject_req(eject_req)
    );

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            failures++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic rd(input logic [15:0] a, output logic [31:0] d);
        io_addr = a;
        #1;
        d = io_rdata;
    endtask

    task automatic wr(input logic [15:0] a, input logic [31:0] d);
        @(negedge clk);
        io_wr = 1'b1; io_addr = a; io_wdata = d;
        @(negedge clk);
        io_wr = 1'b0; io_wdata = '0;
    endtask

    task automatic post_evt(input logic [1:0] k, input logic [4:0] s);
        @(negedge clk);
        evt_valid = 1'b1; evt_kind = k; evt_slot = s;
        @(negedge clk);
        evt_valid = 1'b0;
    endtask

    task automatic eject_test(input string req, input logic [31:0] d, input logic [31:0] exp);
        @(negedge clk);
        io_wr = 1'b1; io_addr = BASE + 16'h8; io_wdata = d;
        @(negedge clk);
        io_wr = 1'b0; io_wdata = '0;
        check(req, eject_req, exp);
        @(negedge clk);
        check(req, eject_req, 32'h0);
    endtask

    initial begin
        #400000;
        if (!done) begin
            failures++;
            checks++;
            $display("FAIL watchdog actual=hung expected=done");
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

    initial begin
        logic [31:0] d;
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);

        // R1 reset state
        rd(BASE + 16'h0, d); check("R1 up", d, 32'h0);
        rd(BASE + 16'h4, d); check("R1 down", d, 32'h0);
        check("R1 gpe", {31'b0, gpe_hp_sts}, 32'h0);
        check("R1 eject", eject_req, 32'h0);
        // R9 removability mask
        rd(BASE + 16'hC, d); check("R9 rmv", d, ~STRAP);

        // table walk: R3 R4 R5 R6
        for (int i = 0; i < NV; i++) begin
            wr(GPE, 32'h2);
            post_evt(VECS[i].kind, VECS[i].slot);
            rd(BASE + 16'h0, d); check("R3/R4/R6 up", d, VECS[i].up);
            rd(BASE + 16'h4, d); check("R3/R4/R6 down", d, VECS[i].down);
            rd(GPE, d); check("R5 gpe", d, {30'b0, VECS[i].gpe, 1'b0});
        end

        // R5 clear and set in same cycle: set wins
        @(negedge clk);
        io_wr = 1'b1; io_addr = GPE; io_wdata = 32'h2;
        evt_valid = 1'b1; evt_kind = 2'd2; evt_slot = 5'd9;
        @(negedge clk);
        io_wr = 1'b0; evt_valid = 1'b0;
        check("R5 set wins", {31'b0, gpe_hp_sts}, 32'h1);
        wr(GPE, 32'h2);
        check("R5 clear", {31'b0, gpe_hp_sts}, 32'h0);

        // R10 read-only windows
        wr(BASE + 16'h4, 32'hFFFF_FFFF);
        rd(BASE + 16'h4, d); check("R10 down write ignored", d, 32'h0000_0200);
        wr(BASE + 16'h0, 32'hFFFF_FFFF);
        rd(BASE + 16'h0, d); check("R10 up write ignored", d, 32'h0);
        rd(BASE + 16'h8, d); check("R10 eject reads zero", d, 32'h0);
        wr(BASE + 16'hC, 32'h0);
        rd(BASE + 16'hC, d); check("R9 rmv write ignored", d, ~STRAP);
        rd(BASE + 16'h10, d); check("R2 unmapped", d, 32'h0);

        // R7 R8 eject
        eject_test("R7 lowest bit slot1", 32'h0000_0006, 32'h0000_0002);
        eject_test("R7 slot31", 32'h8000_0000, 32'h8000_0000);
        eject_test("R8 fixed slot0", 32'h0000_0005, 32'h0);
        eject_test("R8 zero write", 32'h0, 32'h0);

        // R1 reset again clears state
        post_evt(2'd1, 5'd4);
        @(negedge clk); rst = 1'b1;
        @(negedge clk); rst = 1'b0;
        rd(BASE + 16'h0, d); check("R1 up after reset", d, 32'h0);
        check("R1 gpe after reset", {31'b0, gpe_hp_sts}, 32'h0);

        done = 1'b1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

endmodule